// File: doc/BRIEF.md
# SPI Switch-Bank Control Slave

This block is the serial control front end for a bank of eight single-pole single-throw switches. A host drives chip select, serial clock and serial data in SPI mode 0: the clock idles low, the slave samples data on the rising clock edge and changes its serial output after the falling edge. The block holds an 8-bit switch-enable register that drives the switch bank in parallel, and a 3-bit sticky error register. The SPI pins are sampled by a faster system clock through two-stage synchronizers, and every action is taken on an edge that this oversampling detects.

After reset the block is in addressing mode. Each transaction is a 24-bit frame, sent most significant bit first: bit 23 selects read (1) or write (0), bits 22:16 hold a register address, bits 15:8 hold data and bits 7:0 hold a CRC-8 over bits 23:8. The frame is decoded when chip select rises. A wrong clock count, a bad CRC or an unknown address sets an error bit and the frame has no other effect. Read data comes back on the serial output during the following frame. The write command 0x2500 (bits 23:8) moves the block into daisy-chain mode, which only reset leaves. In that mode the block is an 8-bit shift stage: several devices share chip select and clock, each serial output feeds the next device's serial input, and the switch register loads from the shift stage when chip select rises.

The control state machine has four states. ST_ADDR_IDLE goes to ST_ADDR_XFER when chip select falls. ST_ADDR_XFER returns to ST_ADDR_IDLE when chip select rises, or goes to ST_CHAIN_IDLE if the frame was a valid mode-change command. ST_CHAIN_IDLE goes to ST_CHAIN_XFER when chip select falls. ST_CHAIN_XFER returns to ST_CHAIN_IDLE when chip select rises.

Top module: `swb_spi_slave`

## Requirements
- R1: After reset, sw_en is 0x00, err_flags is 0, the block is in addressing mode, and spi_sdo is low outside a frame.
- R2: In addressing mode, a valid 24-bit write frame to address 0x01 loads bits 15:8 into sw_en when chip select rises. Input bits are sampled on rising SCLK edges, MSB first.
- R3: After a valid read frame (bit 23 = 1), the first 8 SDO bits of the next frame carry the addressed register, MSB first, and the remaining bits are 0. Address 0x01 reads sw_en and address 0x02 reads {5'b0, err_flags}. After any other frame, the next frame returns all zeros. A read changes no register.
- R4: An addressing-mode frame with a rising SCLK count other than 24 sets err_flags bit 0 and has no other effect.
- R5: Bits 7:0 of a frame must equal the CRC-8 (polynomial 0x07, seed 0x00, MSB first) of bits 23:8. A mismatch sets err_flags bit 2 and blocks the access. Each frame sets at most one error bit, checked in this order: count, then CRC, then address.
- R6: An access to any address other than 0x01 or 0x02, apart from the mode command, sets err_flags bit 1 and has no other effect.
- R7: Error bits are sticky. A valid write to address 0x02 clears each error bit whose data bit is 1 and leaves the other error bits unchanged.
- R8: A valid write whose bits 23:8 equal 0x2500 switches the block to daisy-chain mode without changing sw_en or err_flags. Later frames, including valid addressing frames, do not leave daisy-chain mode; only reset does.
- R9: In daisy-chain mode, the SDO value sampled at each rising SCLK edge equals the SDI bit sampled 8 rising edges earlier. Before that, it is the shift-stage contents carried over from the last frame (0 after reset). SDO changes only after falling edges.
- R10: In daisy-chain mode, sw_en stays unchanged while chip select is low. When chip select rises, sw_en takes the last 8 bits shifted in, with the last bit as bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, idles low (mode 0) |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block |
| sw_en | output | 8 | Parallel switch-enable bus |
| err_flags | output | 3 | Sticky error flags: bit 0 count, bit 1 address, bit 2 CRC |

## Verification
Each SPI pin reaches the logic three system cycles after it changes: two synchronizer stages and one edge-detect register. So SDO settles three cycles after an SCLK falling edge, and sw_en and err_flags settle three cycles after chip select rises. The bench holds each SCLK phase for six system cycles and samples SDO at the end of the low phase, just before the rising edge that uses it. It compares register results eight cycles after chip select rises. Read data is checked one frame late, in the frame that carries it. Daisy-chain output is compared bit by bit against a bench-side 8-bit shift model, and sw_en is also checked in the middle of a chain frame.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        ST_ADDR_IDLE,
        ST_ADDR_XFER,
        ST_CHAIN_IDLE,
        ST_CHAIN_XFER
    } swb_state_t;

    localparam int          CRC_W    = 8;
    localparam logic [7:0]  CRC_POLY = 8'h07;
    localparam int          ERR_W    = 3;
    localparam int          ERR_CNT  = 0;
    localparam int          ERR_ADDR = 1;
    localparam int          ERR_CRC  = 2;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[CRC_W-1] ^ b;
        n  = {c[CRC_W-2:0], 1'b0};
        if (fb) n = n ^ CRC_POLY;
        return n;
    endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/swb_edge.sv
module swb_edge #(
    parameter int           N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] =  lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] &  prev_q[g];
    end
endmodule

// File: rtl/swb_frame_check.sv
module swb_frame_check
    import swb_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter bit CRC_EN  = 1'b1,
    parameter int CMD_W   = 1 + ADDR_W + DATA_W,
    parameter int FRAME_W = CMD_W + (CRC_EN ? CRC_W : 0),
    parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic [FRAME_W-1:0] rx_word,
    input  logic [CNT_W-1:0]   bit_cnt,
    output logic               cnt_err,
    output logic               crc_err,
    output logic               addr_err,
    output logic               is_read,
    output logic               mode_cmd,
    output logic               sel_sw,
    output logic               sel_err,
    output logic [DATA_W-1:0]  data
);
    localparam logic [ADDR_W-1:0] ADDR_SW   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ERR  = ADDR_W'(2);
    localparam logic [CMD_W-1:0]  MODE_WORD = {1'b0, ADDR_W'(7'h25), DATA_W'(0)};

    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;

    assign cmd      = rx_word[FRAME_W-1 -: CMD_W];
    assign addr     = cmd[CMD_W-2 -: ADDR_W];
    assign data     = cmd[DATA_W-1:0];
    assign is_read  = cmd[CMD_W-1];
    assign cnt_err  = (bit_cnt != CNT_W'(FRAME_W));
    assign mode_cmd = (cmd == MODE_WORD);
    assign sel_sw   = (addr == ADDR_SW);
    assign sel_err  = (addr == ADDR_ERR);
    assign addr_err = !(sel_sw || sel_err || mode_cmd);

    if (CRC_EN) begin : g_crc
        logic [CRC_W-1:0] crc_calc;
        always_comb begin
            crc_calc = '0;
            for (int i = CMD_W - 1; i >= 0; i--) crc_calc = crc_step(crc_calc, cmd[i]);
        end
        assign crc_err = (crc_calc != rx_word[CRC_W-1:0]);
    end else begin : g_no_crc
        assign crc_err = 1'b0;
    end
endmodule

// File: rtl/swb_spi_slave.sv
module swb_spi_slave
    import swb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter bit CRC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic [DATA_W-1:0] sw_en,
    output logic [ERR_W-1:0]  err_flags
);
    localparam int CMD_W   = 1 + ADDR_W + DATA_W;
    localparam int FRAME_W = CMD_W + (CRC_EN ? CRC_W : 0);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

    // synchronized pins: {cs_n, sclk, sdi}
    logic [2:0] pins_s;
    logic       cs_n_s, sclk_s, sdi_s;
    logic [1:0] rise, fall;
    logic       cs_rise, cs_fall, sclk_rise, sclk_fall;

    swb_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sclk, spi_sdi}), .dout(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s} = pins_s;

    swb_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl({cs_n_s, sclk_s}), .rise(rise), .fall(fall)
    );
    assign {cs_rise, sclk_rise} = rise;
    assign {cs_fall, sclk_fall} = fall;

    swb_state_t state_q, state_d;

    logic [FRAME_W-1:0] rx_q, tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  sw_q, rd_pend_q, chain_sr_q;
    logic [ERR_W-1:0]   err_q;
    logic               chain_out_q;

    logic              chk_cnt_err, chk_crc_err, chk_addr_err;
    logic              chk_read, chk_mode, chk_sel_sw, chk_sel_err;
    logic [DATA_W-1:0] chk_data;

    swb_frame_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CRC_EN(CRC_EN)) u_chk (
        .rx_word(rx_q), .bit_cnt(cnt_q),
        .cnt_err(chk_cnt_err), .crc_err(chk_crc_err), .addr_err(chk_addr_err),
        .is_read(chk_read), .mode_cmd(chk_mode),
        .sel_sw(chk_sel_sw), .sel_err(chk_sel_err), .data(chk_data)
    );

    logic frame_ok, addr_end, chain_end, err_clr_go, in_xfer;
    assign frame_ok   = !chk_cnt_err && !chk_crc_err && !chk_addr_err;
    assign addr_end   = (state_q == ST_ADDR_XFER) && cs_rise;
    assign chain_end  = (state_q == ST_CHAIN_XFER) && cs_rise;
    assign err_clr_go = addr_end && frame_ok && !chk_read && chk_sel_err;
    assign in_xfer    = (state_q == ST_ADDR_XFER) || (state_q == ST_CHAIN_XFER);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ADDR_IDLE:  if (cs_fall) state_d = ST_ADDR_XFER;
            ST_ADDR_XFER:  if (cs_rise) state_d = (frame_ok && chk_mode) ? ST_CHAIN_IDLE : ST_ADDR_IDLE;
            ST_CHAIN_IDLE: if (cs_fall) state_d = ST_CHAIN_XFER;
            ST_CHAIN_XFER: if (cs_rise) state_d = ST_CHAIN_IDLE;
            default:       state_d = ST_ADDR_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            tx_q        <= '0;
            cnt_q       <= '0;
            sw_q        <= '0;
            err_q       <= '0;
            rd_pend_q   <= '0;
            chain_sr_q  <= '0;
            chain_out_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR_IDLE: if (cs_fall) begin
                    cnt_q <= '0;
                    tx_q  <= {rd_pend_q, {(FRAME_W-DATA_W){1'b0}}};
                end
                ST_ADDR_XFER: begin
                    if (sclk_rise) begin
                        rx_q <= {rx_q[FRAME_W-2:0], sdi_s};
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end
                    if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
                    if (cs_rise) begin
                        if (chk_cnt_err)       err_q[ERR_CNT]  <= 1'b1;
                        else if (chk_crc_err)  err_q[ERR_CRC]  <= 1'b1;
                        else if (chk_addr_err) err_q[ERR_ADDR] <= 1'b1;
                        else if (err_clr_go)   err_q <= err_q & ~chk_data[ERR_W-1:0];
                        if (frame_ok && !chk_read && chk_sel_sw) sw_q <= chk_data;
                        if (frame_ok && chk_read)
                            rd_pend_q <= chk_sel_sw ? sw_q : DATA_W'(err_q);
                        else
                            rd_pend_q <= '0;
                    end
                end
                ST_CHAIN_IDLE: if (cs_fall) chain_out_q <= chain_sr_q[DATA_W-1];
                ST_CHAIN_XFER: begin
                    if (sclk_rise) chain_sr_q  <= {chain_sr_q[DATA_W-2:0], sdi_s};
                    if (sclk_fall) chain_out_q <= chain_sr_q[DATA_W-1];
                    if (cs_rise)   sw_q        <= chain_sr_q;
                end
                default: ;
            endcase
        end
    end

    // serial output
    always_comb begin
        unique case (state_q)
            ST_ADDR_XFER:  spi_sdo = tx_q[FRAME_W-1];
            ST_CHAIN_XFER: spi_sdo = chain_out_q;
            default:       spi_sdo = 1'b0;
        endcase
    end

    assign sw_en     = sw_q;
    assign err_flags = err_q;

    // assertions
    assert_sw_frozen_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && !cs_rise) |=> $stable(sw_q));

    assert_bad_count_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_end && chk_cnt_err) |=> ($stable(sw_q) && (rd_pend_q == '0)));

    assert_crc_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_end && chk_crc_err) |=> $stable(sw_q));

    assert_bad_addr_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_end && chk_addr_err) |=> $stable(sw_q));

    assert_chain_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHAIN_IDLE) || (state_q == ST_CHAIN_XFER)) |=>
        ((state_q == ST_CHAIN_IDLE) || (state_q == ST_CHAIN_XFER)));

    assert_err_clear_only_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_go |=> ((err_q & $past(err_q)) == $past(err_q)));

    assert_one_new_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> ($countones(err_q & ~$past(err_q)) <= 1));
endmodule

// File: tb/tb_swb_spi_slave.sv
`timescale 1ns/1ps
module tb_swb_spi_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo;
    logic [7:0] sw_en;
    logic [2:0] err;

    always #2.5 clk = ~clk;

    swb_spi_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_sdi(sdi), .spi_sdo(sdo), .sw_en(sw_en), .err_flags(err)
    );

    localparam int K_SW = 0, K_ERR = 1, K_RD = 2, K_BIT = 3, K_QUIET = 4;
    typedef struct { int kind; string req; logic [7:0] exp; } item_t;
    item_t exp_q[$];
    item_t it;
    event  chk_ev;

    int         n_checks = 0, n_fail = 0;
    logic [7:0] cap_byte, act;
    logic       obs_bit;
    logic       chain_tb = 1'b0;
    logic [7:0] model = 8'h00;
    logic [7:0] sw_model = 8'h00;
    bit         done = 0;

    // monitor: pops expected items and compares against the ports
    always begin
        @(chk_ev);
        while (exp_q.size() != 0) begin
            it = exp_q.pop_front();
            case (it.kind)
                K_SW:    act = sw_en;
                K_ERR:   act = {5'b0, err};
                K_RD:    act = cap_byte;
                K_BIT:   act = {7'b0, obs_bit};
                default: act = {7'b0, sdo};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input string req, input logic [7:0] e);
        item_t x;
        x.kind = kind; x.req = req; x.exp = e;
        exp_q.push_back(x);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire();
        -> chk_ev;
        @(negedge clk);
    endtask

    function automatic logic [7:0] crc8(input logic [15:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            logic fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [23:0] mk(input logic rd, input logic [6:0] a, input logic [7:0] d);
        logic [15:0] cmd = {rd, a, d};
        return {cmd, crc8(cmd)};
    endfunction

    task automatic frame(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wait_clk(HALF);
        cap_byte = 8'h00;
        for (int i = n - 1; i >= 0; i--) begin
            int k = n - 1 - i;
            sdi = bits[i];
            wait_clk(HALF);
            obs_bit = sdo;
            if (k < 8) cap_byte = {cap_byte[6:0], sdo};
            if (chain_tb) begin
                push(K_BIT, "R9", {7'b0, model[7]});
                model = {model[6:0], bits[i]};
                if (k == 7) push(K_SW, "R10", sw_model);
                fire();
            end
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chain_tb = 1'b0;
        model = 8'h00;
        sw_model = 8'h00;
    endtask

    initial begin
        do_reset();
        push(K_SW, "R1", 8'h00); push(K_ERR, "R1", 8'h00); push(K_QUIET, "R1", 8'h00); fire();

        frame({8'h0, mk(0, 7'h01, 8'hA5)}, 24);
        push(K_SW, "R2", 8'hA5); push(K_ERR, "R2", 8'h00); push(K_QUIET, "R1", 8'h00); fire();

        frame({8'h0, mk(1, 7'h01, 8'h00)}, 24);
        push(K_SW, "R3", 8'hA5); fire();

        frame({8'h0, mk(0, 7'h01, 8'h3C)}, 24);
        push(K_RD, "R3", 8'hA5); push(K_SW, "R2", 8'h3C); fire();

        frame({8'h0, mk(0, 7'h01, 8'h3C)}, 24);
        push(K_RD, "R3", 8'h00); fire();

        // short frame: 20 bits
        frame({12'h0, mk(0, 7'h01, 8'hFF) >> 4}, 20);
        push(K_ERR, "R4", 8'h01); push(K_SW, "R4", 8'h3C); fire();

        frame({8'h0, mk(1, 7'h02, 8'h00)}, 24);
        push(K_ERR, "R3", 8'h01); fire();
        frame({8'h0, mk(0, 7'h01, 8'h3C)}, 24);
        push(K_RD, "R3", 8'h01); fire();

        frame({8'h0, mk(0, 7'h02, 8'h01)}, 24);
        push(K_ERR, "R7", 8'h00); fire();

        frame({8'h0, mk(0, 7'h01, 8'hFF) ^ 24'h000001}, 24);
        push(K_ERR, "R5", 8'h04); push(K_SW, "R5", 8'h3C); fire();

        frame({8'h0, mk(0, 7'h05, 8'h77)}, 24);
        push(K_ERR, "R6", 8'h06); push(K_SW, "R6", 8'h3C); fire();

        frame({8'h0, mk(0, 7'h02, 8'h04)}, 24);
        push(K_ERR, "R7", 8'h02); fire();

        // long frame: 25 bits, only the count flag may be added
        frame({7'h0, mk(0, 7'h01, 8'h99), 1'b0}, 25);
        push(K_ERR, "R5", 8'h03); push(K_SW, "R4", 8'h3C); fire();

        frame({8'h0, mk(0, 7'h02, 8'h07)}, 24);
        push(K_ERR, "R7", 8'h00); fire();

        // mode change
        frame({8'h0, mk(0, 7'h25, 8'h00)}, 24);
        push(K_ERR, "R8", 8'h00); push(K_SW, "R8", 8'h3C); fire();

        chain_tb = 1'b1;
        sw_model = 8'h3C;
        frame({16'h0, 16'hC3A5}, 16);
        sw_model = model;
        push(K_SW, "R10", sw_model); fire();

        frame({20'h0, 12'h5F0}, 12);
        sw_model = model;
        push(K_SW, "R10", sw_model); push(K_QUIET, "R1", 8'h00); fire();

        // a valid addressing write is just shifted through
        frame({8'h0, mk(0, 7'h01, 8'h11)}, 24);
        sw_model = model;
        push(K_SW, "R8", sw_model); push(K_ERR, "R8", 8'h00); fire();

        do_reset();
        push(K_SW, "R1", 8'h00); push(K_ERR, "R1", 8'h00); fire();
        frame({8'h0, mk(0, 7'h01, 8'h66)}, 24);
        push(K_SW, "R8", 8'h66); fire();

        wait_clk(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule